// File: doc/BRIEF.md
# Windowed Segment Transmitter

This block sends a message to a peer as a numbered series of fixed-width segments. It uses a register-style channel. For each segment the block first places the payload on a data register. It then advances an 8-bit sequence counter. The peer reads a counter value ahead of its own acknowledge value as fresh data. It answers by raising its acknowledge counter. A synchronisation bit and the peer's synchronisation acknowledge keep both sides in step.

The block does not wait for each answer before it sends the next segment. Several segments may be unanswered at a time, up to a fixed window. A watchdog counts the cycles since the last counter advance and declares the outstanding data lost if no answer arrives in time. The message is complete only when the acknowledge counter has reached the sequence number of the final segment.

The payload source sits outside the block and is addressed by segment index. A start pulse with a segment count begins each message. Every message begins with a resynchronisation, so the first segment always carries sequence number 1.

Top module: `segtx_window_sender`

## Requirements
- R1: While reset is held and after its release, sync_out, seq_out, done, lost_err and busy are all 0.
- R2: Segments go out in index order. The payload for index k shows on pay_out at least one cycle before seq_out steps by +1, and it is unchanged in the cycle of that step. Segment k (counting from 0) carries sequence number k+1 after the start.
- R3: The modulo-256 difference between seq_out and the last accepted acknowledge never exceeds 7. While that difference is 7, seq_out does not advance.
- R4: If peer_sync_ack is 0 while a message is active, then sync_out and seq_out are 0 in the next cycle. sync_out stays 0 until peer_sync_ack is seen at 1. The message then restarts from segment index 0.
- R5: A start pulse while idle clears lost_err, sets busy and drives sync_out and seq_out to 0 in the next cycle. A start pulse while busy is ignored.
- R6: An acknowledge value a is accepted only if 0 < (a − last accepted) mod 256 ≤ (seq_out − last accepted) mod 256. Any other value, such as one ahead of seq_out, is ignored.
- R7: done is a one-cycle pulse that comes one cycle after the acknowledge matching the final segment's sequence number is presented. busy is 0 from that cycle on.
- R8: If data is outstanding and seq_out has not advanced for more than tmo_limit cycles, lost_err rises exactly tmo_limit+1 cycles after the last advance. At the same time busy falls. lost_err then stays 1 until the next start.
- R9: The counters wrap modulo 256, so a message of more than 256 segments completes, and seq_out then ends at the segment count mod 256.
- R10: A message of zero segments completes with a done pulse once synchronisation is established, and sends no segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a message (taken while idle) |
| seg_total | input | CNT_W (10) | Number of segments in the message, latched at start |
| tmo_limit | input | TMO_W (16) | Allowed cycles without a counter advance while data is outstanding |
| seg_idx | output | CNT_W (10) | Index of the segment the block is fetching |
| seg_data | input | DATA_W (16) | Payload of segment seg_idx, read combinationally |
| pay_out | output | DATA_W (16) | Payload register offered to the peer |
| seq_out | output | SEQ_W (8) | Sequence counter offered to the peer |
| sync_out | output | 1 | Synchronisation bit to the peer |
| peer_ack | input | SEQ_W (8) | Peer acknowledge counter |
| peer_sync_ack | input | 1 | Peer synchronisation acknowledge |
| busy | output | 1 | A message is in progress |
| done | output | 1 | One-cycle pulse when the message is fully acknowledged |
| lost_err | output | 1 | Sticky flag: outstanding data timed out |

## Verification
Each output has a fixed latency from its cause. A payload appears one cycle before its counter advance. sync_out and seq_out clear one cycle after a start or a lost synchronisation acknowledge. done follows the final acknowledge by one cycle. lost_err rises exactly tmo_limit+1 cycles after the last advance. The bench drives every input on the falling edge and samples on the falling edge after the rising edge at which the result is due. It checks the cycle before that point as well, so both early and late responses are caught. A scoreboard queue holds the expected payloads. It is compared whenever the counter steps by one, and it is refilled when a resynchronisation restarts the message.

// File: rtl/segtx_pkg.sv
package segtx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SYNC = 2'd1,
      ST_RUN  = 2'd2
   } segtx_state_e;

endpackage

// File: rtl/segtx_window.sv
// Sequence counter and acknowledge tracker; all differences are modulo 2**SEQ_W.
module segtx_window #(
   parameter int SEQ_W  = 8,
   parameter int WINDOW = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bump,
   input  logic             ack_en,
   input  logic [SEQ_W-1:0] peer_ack,
   output logic [SEQ_W-1:0] seq,
   output logic [SEQ_W-1:0] exp_ack,
   output logic [SEQ_W-1:0] outstanding,
   output logic [SEQ_W-1:0] ack_gain,
   output logic             room
);
   localparam logic [SEQ_W-1:0] WIN_V = SEQ_W'(WINDOW);

   logic [SEQ_W-1:0] seq_q, exp_q, ack_d;
   logic             ack_ok;

   always_comb begin
      outstanding = seq_q - exp_q;
      ack_d       = peer_ack - exp_q;
      ack_ok      = ack_en && (ack_d != '0) && (ack_d <= outstanding);
      ack_gain    = ack_ok ? ack_d : '0;
      room        = outstanding < WIN_V;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_q <= '0;
         exp_q <= '0;
      end else if (clr) begin
         seq_q <= '0;
         exp_q <= '0;
      end else begin
         if (bump)   seq_q <= seq_q + 1'b1;
         if (ack_ok) exp_q <= peer_ack;
      end
   end

   assign seq     = seq_q;
   assign exp_ack = exp_q;
endmodule

// File: rtl/segtx_watchdog.sv
// Counts cycles since the last counter advance while data is outstanding.
module segtx_watchdog #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             bump,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   logic [TMO_W-1:0] cnt_q;

   assign expired = arm && (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (bump || !arm) cnt_q <= '0;
      else if (!expired)     cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/segtx_ctrl.sv
// Message sequencing: sync handshake, two-step offer, completion and timeout.
module segtx_ctrl
   import segtx_pkg::*;
#(
   parameter int CNT_W  = 10,
   parameter int SEQ_W  = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  seg_total,
   input  logic [DATA_W-1:0] seg_data,
   input  logic              peer_sync_ack,
   input  logic              room,
   input  logic [SEQ_W-1:0]  ack_gain,
   input  logic              expired,
   output logic              in_run,
   output logic              ack_en,
   output logic              bump,
   output logic              win_clr,
   output logic [CNT_W-1:0]  seg_idx,
   output logic [DATA_W-1:0] pay_out,
   output logic              sync_out,
   output logic              busy,
   output logic              done,
   output logic              lost_err
);
   segtx_state_e      state_q;
   logic [CNT_W-1:0]  total_q, sent_q, acked_q, acked_nx;
   logic [DATA_W-1:0] pay_q;
   logic              phase_q, sync_q, done_q, err_q;
   logic              run_ok, load, finish;

   always_comb begin
      in_run   = (state_q == ST_RUN);
      run_ok   = in_run && peer_sync_ack && !expired;
      ack_en   = run_ok;
      acked_nx = acked_q + CNT_W'(ack_gain);
      bump     = run_ok && phase_q;
      load     = run_ok && !phase_q && (sent_q < total_q) && room;
      finish   = run_ok && !phase_q && (sent_q == total_q) && (acked_nx == total_q);
      win_clr  = ((state_q == ST_IDLE) && start) || (in_run && !peer_sync_ack);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         total_q <= '0;
         sent_q  <= '0;
         acked_q <= '0;
         pay_q   <= '0;
         phase_q <= 1'b0;
         sync_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  total_q <= seg_total;
                  err_q   <= 1'b0;
                  sync_q  <= 1'b0;
                  sent_q  <= '0;
                  acked_q <= '0;
                  phase_q <= 1'b0;
                  state_q <= ST_SYNC;
               end
            end
            ST_SYNC: begin
               if (peer_sync_ack) begin
                  sync_q  <= 1'b1;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (!peer_sync_ack) begin
                  sync_q  <= 1'b0;
                  sent_q  <= '0;
                  acked_q <= '0;
                  phase_q <= 1'b0;
                  state_q <= ST_SYNC;
               end else if (expired) begin
                  err_q   <= 1'b1;
                  phase_q <= 1'b0;
                  state_q <= ST_IDLE;
               end else begin
                  acked_q <= acked_nx;
                  if (finish) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (load) begin
                     pay_q   <= seg_data;
                     phase_q <= 1'b1;
                  end else if (bump) begin
                     sent_q  <= sent_q + 1'b1;
                     phase_q <= 1'b0;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign seg_idx  = sent_q;
   assign pay_out  = pay_q;
   assign sync_out = sync_q;
   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign lost_err = err_q;
endmodule

// File: rtl/segtx_window_sender.sv
module segtx_window_sender #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 10,
   parameter int SEQ_W  = 8,
   parameter int WINDOW = 7,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  seg_total,
   input  logic [TMO_W-1:0]  tmo_limit,
   output logic [CNT_W-1:0]  seg_idx,
   input  logic [DATA_W-1:0] seg_data,
   output logic [DATA_W-1:0] pay_out,
   output logic [SEQ_W-1:0]  seq_out,
   output logic              sync_out,
   input  logic [SEQ_W-1:0]  peer_ack,
   input  logic              peer_sync_ack,
   output logic              busy,
   output logic              done,
   output logic              lost_err
);
   localparam int GAIN_W = $clog2(WINDOW + 1);

   generate
      if (WINDOW < 1 || WINDOW >= (1 << SEQ_W)) begin : g_bad_window
         $error("WINDOW must lie in 1 .. 2**SEQ_W-1");
      end
      if (CNT_W < GAIN_W) begin : g_bad_cnt
         $error("CNT_W too narrow for the window");
      end
      if (DATA_W < 1 || TMO_W < 1) begin : g_bad_width
         $error("DATA_W and TMO_W must be positive");
      end
   endgenerate

   logic             in_run, ack_en, bump, win_clr, room, expired, arm;
   logic [SEQ_W-1:0] exp_ack, outstanding, ack_gain;

   assign arm = in_run && (outstanding != '0);

   segtx_window #(.SEQ_W(SEQ_W), .WINDOW(WINDOW)) u_win (
      .clk(clk), .rst_n(rst_n), .clr(win_clr), .bump(bump), .ack_en(ack_en),
      .peer_ack(peer_ack), .seq(seq_out), .exp_ack(exp_ack),
      .outstanding(outstanding), .ack_gain(ack_gain), .room(room)
   );

   segtx_watchdog #(.TMO_W(TMO_W)) u_wdg (
      .clk(clk), .rst_n(rst_n), .arm(arm), .bump(bump),
      .limit(tmo_limit), .expired(expired)
   );

   segtx_ctrl #(.CNT_W(CNT_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .seg_total(seg_total),
      .seg_data(seg_data), .peer_sync_ack(peer_sync_ack), .room(room),
      .ack_gain(ack_gain), .expired(expired), .in_run(in_run), .ack_en(ack_en),
      .bump(bump), .win_clr(win_clr), .seg_idx(seg_idx), .pay_out(pay_out),
      .sync_out(sync_out), .busy(busy), .done(done), .lost_err(lost_err)
   );
endmodule

// File: rtl/segtx_checker.sv
module segtx_checker #(
   parameter int DATA_W = 16,
   parameter int SEQ_W  = 8,
   parameter int WINDOW = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [SEQ_W-1:0]  seq_out,
   input logic [SEQ_W-1:0]  exp_ack,
   input logic [DATA_W-1:0] pay_out,
   input logic              sync_out,
   input logic              busy,
   input logic              done,
   input logic              lost_err
);
   assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      SEQ_W'(seq_out - exp_ack) <= SEQ_W'(WINDOW));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_out != $past(seq_out)) |-> (seq_out == SEQ_W'($past(seq_out) + 1'b1)) || (seq_out == '0));

   assert_pay_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_out == SEQ_W'($past(seq_out) + 1'b1)) |-> (pay_out == $past(pay_out)));

   assert_nosync_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_out |-> (seq_out == '0));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_err && !start) |=> lost_err);

   assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lost_err) |-> !busy);
endmodule

bind segtx_window_sender segtx_checker #(
   .DATA_W(DATA_W), .SEQ_W(SEQ_W), .WINDOW(WINDOW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .seq_out(seq_out),
   .exp_ack(exp_ack), .pay_out(pay_out), .sync_out(sync_out),
   .busy(busy), .done(done), .lost_err(lost_err)
);

// File: tb/tb_segtx_window_sender.sv
`timescale 1ns/1ps
module tb_segtx_window_sender;
   localparam int DATA_W = 16, CNT_W = 10, SEQ_W = 8, TMO_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [CNT_W-1:0]  seg_total = '0;
   logic [TMO_W-1:0]  tmo_limit = 16'd1000;
   logic [CNT_W-1:0]  seg_idx;
   logic [DATA_W-1:0] seg_data, pay_out;
   logic [SEQ_W-1:0]  seq_out;
   logic [SEQ_W-1:0]  peer_ack = '0;
   logic              peer_sync_ack = 1'b1;
   logic              sync_out, busy, done, lost_err;

   int checks = 0, failures = 0;
   int peer_auto = 1;
   logic [DATA_W-1:0] sb_q[$];

   always #5 clk = ~clk;

   function automatic logic [DATA_W-1:0] payload_of(input int k);
      return DATA_W'(k * 37 + 16'h05A3);
   endfunction

   assign seg_data = payload_of(int'(seg_idx));

   segtx_window_sender dut (
      .clk(clk), .rst_n(rst_n), .start(start), .seg_total(seg_total),
      .tmo_limit(tmo_limit), .seg_idx(seg_idx), .seg_data(seg_data),
      .pay_out(pay_out), .seq_out(seq_out), .sync_out(sync_out),
      .peer_ack(peer_ack), .peer_sync_ack(peer_sync_ack), .busy(busy),
      .done(done), .lost_err(lost_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // peer model: ack follows the counter when automatic, zero while unsynced
   initial begin
      forever begin
         @(negedge clk);
         if (!sync_out) peer_ack = '0;
         else if (peer_auto != 0) peer_ack = seq_out;
      end
   end

   // monitor: compare payload with the scoreboard at each +1 step of the counter
   initial begin
      logic [SEQ_W-1:0] last = '0;
      forever begin
         @(negedge clk);
         if (rst_n && seq_out == SEQ_W'(last + 1'b1)) begin
            if (sb_q.size() == 0) check(1'b0, "R2", "segment with empty scoreboard", int'(pay_out), -1);
            else begin
               logic [DATA_W-1:0] e;
               e = sb_q.pop_front();
               check(pay_out == e, "R2", "payload order", int'(pay_out), int'(e));
            end
         end
         last = seq_out;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   task automatic push_msg(input int n);
      sb_q.delete();
      for (int k = 0; k < n; k++) sb_q.push_back(payload_of(k));
   endtask

   task automatic launch(input int n);
      push_msg(n);
      @(negedge clk);
      seg_total = CNT_W'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req, input int max_cyc);
      bit seen = 0;
      for (int i = 0; i < max_cyc; i++) begin
         if (done) begin seen = 1; break; end
         @(negedge clk);
      end
      check(seen, req, "done pulse seen", int'(seen), 1);
      @(negedge clk);
      check(!done && !busy, "R7", "done is one cycle, busy low", int'(done), 0);
      check(sb_q.size() == 0, "R2", "all payloads delivered", sb_q.size(), 0);
   endtask

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check(!sync_out && seq_out == 0 && !done && !lost_err && !busy, "R1", "state in reset", int'(seq_out), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!sync_out && seq_out == 0 && !busy && !lost_err, "R1", "state after reset", int'(busy), 0);

      // R2/R7 basic stream with automatic acks
      peer_auto = 1;
      launch(5);
      check(busy && !sync_out && seq_out == 0, "R5", "sync cleared after start", int'(sync_out), 0);
      wait_done("R7", 200);
      check(seq_out == 8'd5, "R2", "final sequence number", int'(seq_out), 5);

      // R10 empty message
      launch(0);
      @(negedge clk);
      check(!done, "R10", "no done before sync", int'(done), 0);
      @(negedge clk);
      check(done && seq_out == 0, "R10", "done for empty message", int'(done), 1);
      @(negedge clk);

      // R3 window limit with held acknowledge
      peer_auto = 0;
      peer_ack = '0;
      launch(12);
      repeat (40) @(negedge clk);
      check(seq_out == 8'd7 && busy, "R3", "counter stalls at window", int'(seq_out), 7);
      @(negedge clk);
      peer_ack = 8'd3;
      repeat (12) @(negedge clk);
      check(seq_out == 8'd10, "R3", "window reopens by acked amount", int'(seq_out), 10);
      peer_auto = 1;
      wait_done("R3", 200);

      // R6 bogus and partial acks, R7 exact done timing
      peer_auto = 0;
      peer_ack = '0;
      launch(3);
      repeat (20) @(negedge clk);
      check(seq_out == 8'd3, "R6", "all sent", int'(seq_out), 3);
      peer_ack = 8'd9;
      repeat (10) @(negedge clk);
      check(busy && !done, "R6", "ack ahead of counter ignored", int'(busy), 1);
      peer_ack = 8'd2;
      repeat (3) @(negedge clk);
      check(busy && !done, "R6", "partial ack no completion", int'(busy), 1);
      peer_ack = 8'd3;
      @(negedge clk);
      check(done, "R7", "done one cycle after final ack", int'(done), 1);
      @(negedge clk);
      check(!done && !busy, "R7", "done pulse ends", int'(done), 0);

      // R8 timeout exact cycle and stickiness
      tmo_limit = 16'd20;
      peer_ack = '0;
      launch(2);
      while (seq_out != 8'd2) @(negedge clk);
      repeat (20) @(negedge clk);
      check(!lost_err && busy, "R8", "no error at limit", int'(lost_err), 0);
      @(negedge clk);
      check(lost_err && !busy, "R8", "error at limit+1", int'(lost_err), 1);
      repeat (10) @(negedge clk);
      check(lost_err, "R8", "error sticky", int'(lost_err), 1);
      tmo_limit = 16'd1000;
      peer_auto = 1;
      launch(2);
      check(!lost_err, "R8", "start clears error", int'(lost_err), 0);
      wait_done("R8", 100);

      // R4 resynchronisation mid-message
      launch(20);
      while (seq_out != 8'd5) @(negedge clk);
      peer_sync_ack = 1'b0;
      @(negedge clk);
      check(!sync_out && seq_out == 0, "R4", "sync and counter cleared", int'(seq_out), 0);
      push_msg(20);
      repeat (5) @(negedge clk);
      check(!sync_out && busy, "R4", "sync held low while peer unsynced", int'(sync_out), 0);
      peer_sync_ack = 1'b1;
      @(negedge clk);
      check(sync_out, "R4", "sync raised after peer ack", int'(sync_out), 1);
      wait_done("R4", 300);
      check(seq_out == 8'd20, "R4", "restart from first segment", int'(seq_out), 20);

      // R9 counter wrap over a long message
      launch(300);
      wait_done("R9", 2000);
      check(seq_out == 8'd44, "R9", "counter wrapped", int'(seq_out), 44);

      // R5 start while busy is ignored
      launch(4);
      @(negedge clk);
      start = 1'b1;
      seg_total = CNT_W'(9);
      @(negedge clk);
      start = 1'b0;
      wait_done("R5", 200);
      check(seq_out == 8'd4, "R5", "start while busy ignored", int'(seq_out), 4);

      finish_run();
   end
endmodule